// File: doc/BRIEF.md
# Edge-Cleared Watchdog Timer

This block supervises a processor heartbeat line. Software is expected to change the level of the line at regular intervals. Any change counts as service, whether the line goes up or down. When the line keeps one level for longer than a programmable number of clock ticks, the active-low watchdog output is pulled low. It stays low until the next heartbeat edge, a system reset or a disable clears it. The heartbeat is passed through a two-flop synchroniser before its edges are detected. As a result, pulses as short as one clock period are still seen.

Three other conditions act on the timer. While the system reset from the reset generator is held low, the counter stays at zero, so the timeout window opens only when that reset is released. A supply-low flag drives the output low at once, whatever the timer holds, and the output is released in the same cycle that the flag clears. A heartbeat-valid flag stands for a line that is left floating or tri-stated. While that flag is low, timing is switched off and the output acts only as a low-supply indicator.

Top module: `heartbeat_wdt`

## Requirements
- R1: A change of `beatIn` in either direction clears the timer. If the new level is first sampled at clock edge k, the counter is zero and `wdogN` is released (when `supplyLow` is 0) after edge k+2.
- R2: With `beatValid`=1, `sysResetN`=1 and no heartbeat edge, `wdogN` stays high for the first TIMEOUT_TICKS-1 counting edges and goes low after edge number TIMEOUT_TICKS.
- R3: Once the timeout has fired, `wdogN` stays low for as long as no heartbeat edge arrives, `sysResetN` stays 1 and `beatValid` stays 1.
- R4: While `sysResetN` is 0, the counter is held at zero and any timeout is cleared. Counting starts again from zero at the first edge after release.
- R5: While `supplyLow` is 1, `wdogN` is 0 in the same cycle, without waiting for a clock edge, whatever the timer state.
- R6: When `supplyLow` returns to 0 and no timeout is pending, `wdogN` returns to 1 in the same cycle.
- R7: While `beatValid` is 0, no timeout fires and `wdogN` equals the inverse of `supplyLow`. A level change on `beatIn` during that time is not taken as service once the flag comes back.
- R8: A heartbeat pulse lasting one clock period is taken as service and clears a pending timeout.
- R9: While `rstN` is low, the counter and the timeout are cleared and `wdogN` equals the inverse of `supplyLow`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; one period is one timer tick |
| rstN | input | 1 | Asynchronous active-low logic reset |
| sysResetN | input | 1 | Active-low system reset from the reset generator; holds the timer clear |
| beatIn | input | 1 | Asynchronous heartbeat line from the processor |
| beatValid | input | 1 | 1 when the heartbeat line is actively driven; 0 disables timing |
| supplyLow | input | 1 | 1 while the supply is below its threshold |
| wdogN | output | 1 | Active-low watchdog output |

## Verification
The hardest state to reach is a heartbeat edge that arrives in the very cycle the counter sits at its limit. The edge has to win over the timeout. Every other timing corner depends on the three-cycle path from the line through the synchroniser. The stimulus uses a short timeout parameter and long quiet stretches drawn at random, so the count often lands right at the limit while edges are arriving. A cycle model in the bench follows the same input sequence, and its output is compared with the design's in every cycle. Directed sequences then fix the exact cycle of expiry, of release after an edge, and of release after a one-period pulse.

// File: rtl/heartbeat_wdt_pkg.sv
`timescale 1ns/1ps
package heartbeat_wdt_pkg;

  // Strobes from the control to the counting datapath.
  typedef struct packed {
    logic clearCount;  // zero the tick counter this cycle
    logic advance;     // add one tick to the counter this cycle
  } wdtStrobes_t;

endpackage

// File: rtl/heartbeat_wdt_dp.sv
`timescale 1ns/1ps
module heartbeat_wdt_dp
  import heartbeat_wdt_pkg::*;
#(
  parameter int unsigned TIMEOUT_TICKS = 400_000_000,
  parameter int unsigned SYNC_STAGES   = 2,
  localparam int unsigned CNT_W = (TIMEOUT_TICKS > 2) ? $clog2(TIMEOUT_TICKS) : 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sysResetN,
  input  logic        beatIn,
  input  logic        beatValid,
  input  wdtStrobes_t strobes,
  output logic        beatEdge,
  output logic        atLimit
);

  localparam logic [CNT_W-1:0] LAST_TICK = CNT_W'(TIMEOUT_TICKS - 1);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   prevQ;
  logic [CNT_W-1:0]       tickCnt;

  // Synchroniser chain, one flop per stage.
  for (genvar s = 0; s < SYNC_STAGES; s++) begin : gSync
    if (s == 0) begin : gFirst
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[0] <= 1'b0;
        else       syncQ[0] <= beatIn;
      end
    end else begin : gNext
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[s] <= 1'b0;
        else       syncQ[s] <= syncQ[s-1];
      end
    end
  end

  // Previous sample always follows the line, so a change made while the
  // line is disabled leaves no pending edge behind.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevQ <= 1'b0;
    else       prevQ <= syncQ[SYNC_STAGES-1];
  end

  assign beatEdge = beatValid & (syncQ[SYNC_STAGES-1] ^ prevQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    tickCnt <= '0;
    else if (strobes.clearCount)  tickCnt <= '0;
    else if (strobes.advance)     tickCnt <= tickCnt + 1'b1;
  end

  assign atLimit = (tickCnt == LAST_TICK);

  AST_EDGE_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    beatEdge |=> (tickCnt == '0)); // R1
  AST_SYSRST_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !sysResetN |=> (tickCnt == '0)); // R4
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    tickCnt <= LAST_TICK); // R2

endmodule

// File: rtl/heartbeat_wdt_ctl.sv
`timescale 1ns/1ps
module heartbeat_wdt_ctl
  import heartbeat_wdt_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        sysResetN,
  input  logic        beatValid,
  input  logic        beatEdge,
  input  logic        atLimit,
  output wdtStrobes_t strobes,
  output logic        expired
);

  logic restartTimer;

  // An edge, a system reset or a disable restarts the window.
  assign restartTimer = !sysResetN || !beatValid || beatEdge;

  always_comb begin
    strobes            = '0;
    strobes.clearCount = restartTimer;
    strobes.advance    = !restartTimer && !atLimit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             expired <= 1'b0;
    else if (restartTimer) expired <= 1'b0;
    else if (atLimit)      expired <= 1'b1;
  end

  AST_EXPIRE_AT_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(expired) |-> $past(atLimit)); // R2
  AST_LOW_UNTIL_SERVICE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(expired) |-> $past(!sysResetN || !beatValid || beatEdge)); // R3
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !beatValid |=> !expired); // R7

endmodule

// File: rtl/heartbeat_wdt.sv
`timescale 1ns/1ps
module heartbeat_wdt
  import heartbeat_wdt_pkg::*;
#(
  parameter int unsigned TIMEOUT_TICKS = 400_000_000,
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sysResetN,
  input  logic beatIn,
  input  logic beatValid,
  input  logic supplyLow,
  output logic wdogN
);

  wdtStrobes_t strobes;
  logic        beatEdge;
  logic        atLimit;
  logic        expired;

  heartbeat_wdt_dp #(
    .TIMEOUT_TICKS(TIMEOUT_TICKS),
    .SYNC_STAGES  (SYNC_STAGES)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .sysResetN(sysResetN),
    .beatIn   (beatIn),
    .beatValid(beatValid),
    .strobes  (strobes),
    .beatEdge (beatEdge),
    .atLimit  (atLimit)
  );

  heartbeat_wdt_ctl uCtl (
    .clk      (clk),
    .rstN     (rstN),
    .sysResetN(sysResetN),
    .beatValid(beatValid),
    .beatEdge (beatEdge),
    .atLimit  (atLimit),
    .strobes  (strobes),
    .expired  (expired)
  );

  // Supply override is combinational so both assertion and release are immediate.
  assign wdogN = !(expired || supplyLow);

endmodule

// File: tb/heartbeat_wdt_test.sv
`timescale 1ns/1ps
module heartbeat_wdt_test;

  localparam int LIMIT = 40;

  logic clk = 1'b0;
  logic rstN, sysResetN, beatIn, beatValid, supplyLow;
  logic wdogN;
  int   total = 0;
  int   bad   = 0;

  always #2 clk = ~clk;   // 250 MHz

  heartbeat_wdt #(.TIMEOUT_TICKS(LIMIT)) uut (
    .clk(clk), .rstN(rstN), .sysResetN(sysResetN), .beatIn(beatIn),
    .beatValid(beatValid), .supplyLow(supplyLow), .wdogN(wdogN)
  );

  // Reference cycle model built from the requirements.
  logic m1, m2, mPrev, mExp;
  int   mCnt;
  logic mEdge;
  assign mEdge = beatValid && (m2 != mPrev);

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      m1 <= 0; m2 <= 0; mPrev <= 0; mExp <= 0; mCnt <= 0;
    end else begin
      m1 <= beatIn; m2 <= m1; mPrev <= m2;
      if (!sysResetN || !beatValid || mEdge) begin
        mCnt <= 0; mExp <= 0;
      end else if (mCnt == LIMIT - 1) mExp <= 1;
      else mCnt <= mCnt + 1;
    end
  end

  function automatic logic expectOut(logic exp_, logic sup);
    return !(exp_ || sup);
  endfunction

  task automatic chk(string req, logic act, logic exp_);
    total++;
    if (act !== exp_) begin
      bad++;
      $display("FAIL %s: wdogN=%0b expected=%0b at %0t", req, act, exp_, $time);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #2;
  endtask

  initial begin
    #(200000 * 4);
    bad++;
    $display("FAIL watchdog: run hung, act=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rstN = 0; sysResetN = 0; beatIn = 0; beatValid = 1; supplyLow = 0;
    #9;
    chk("R9 reset state", wdogN, 1'b1);
    supplyLow = 1; #1;
    chk("R9 reset with supply low", wdogN, 1'b0);
    supplyLow = 0;
    cyc(); cyc();
    rstN = 1;
    repeat (4) cyc();
    chk("R4 held by system reset", wdogN, 1'b1);

    // R2: exact expiry cycle after system reset release
    sysResetN = 1;
    for (int i = 1; i <= LIMIT; i++) begin
      cyc();
      if (i < LIMIT) begin
        if (i == LIMIT - 1) chk("R2 last high cycle", wdogN, 1'b1);
        else if (wdogN !== 1'b1) chk("R2 counting", wdogN, 1'b1);
      end else chk("R2 expiry", wdogN, 1'b0);
    end

    // R3: stays low while nothing happens
    for (int i = 0; i < 20; i++) begin
      cyc();
      if (i == 19 || wdogN !== 1'b0) chk("R3 held low", wdogN, 1'b0);
    end

    // R1: rising edge releases after edge k+2
    beatIn = 1;
    cyc(); chk("R1 rise, edge k", wdogN, 1'b0);
    cyc(); chk("R1 rise, edge k+1", wdogN, 1'b0);
    cyc(); chk("R1 rise, edge k+2", wdogN, 1'b1);

    // R1: falling edge also services (let it expire first)
    repeat (LIMIT) cyc();
    chk("R2 second expiry", wdogN, 1'b0);
    beatIn = 0;
    cyc(); cyc(); cyc();
    chk("R1 fall releases", wdogN, 1'b1);

    // R8: one-period pulse
    repeat (LIMIT) cyc();
    chk("R2 before pulse", wdogN, 1'b0);
    beatIn = 1; cyc(); beatIn = 0;
    cyc(); cyc();
    chk("R8 single-period pulse", wdogN, 1'b1);

    // R4: system reset clears a pending timeout
    repeat (LIMIT + 2) cyc();
    chk("R2 before sys reset", wdogN, 1'b0);
    sysResetN = 0; cyc();
    chk("R4 sys reset clears timeout", wdogN, 1'b1);
    sysResetN = 1;

    // R5 / R6: supply override is immediate
    cyc(); supplyLow = 1; #1;
    chk("R5 supply low immediate", wdogN, 1'b0);
    cyc(); supplyLow = 0; #1;
    chk("R6 supply recovery immediate", wdogN, 1'b1);

    // R7: disabled line never times out; toggles while disabled are ignored
    beatValid = 0;
    for (int i = 0; i < 2 * LIMIT; i++) begin
      cyc();
      if (i == 10) beatIn = ~beatIn;
      if (wdogN !== 1'b1 || i == 2 * LIMIT - 1) chk("R7 disabled no timeout", wdogN, 1'b1);
    end
    supplyLow = 1; #1;
    chk("R7 disabled low-supply indicator", wdogN, 1'b0);
    supplyLow = 0;
    beatValid = 1;
    for (int i = 1; i <= LIMIT; i++) cyc();
    chk("R7 no spurious service after enable", wdogN, 1'b0);

    // Random phase against the cycle model
    begin
      int quiet = 0;
      for (int n = 0; n < 6000; n++) begin
        cyc();
        chk("R1/R2/R3/R4/R5 model", wdogN, expectOut(mExp, supplyLow));
        if (n % 150 == 0) quiet = $urandom_range(0, 3);
        if ($urandom_range(0, (quiet == 0) ? 6 : LIMIT + 10) == 0) beatIn = ~beatIn;
        if ($urandom_range(0, 99) < 3) supplyLow = ~supplyLow;
        beatValid = ($urandom_range(0, 99) < 97) ? 1'b1 : (($urandom_range(0, 1) == 0) ? 1'b0 : beatValid);
        sysResetN = ($urandom_range(0, 199) == 0) ? 1'b0 : 1'b1;
        #1;
        chk("R5/R6 model after drive", wdogN, !(mExp || supplyLow));
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule